// File: doc/BRIEF.md
# Float to Int32 Converter

This block turns an unpacked floating-point operand into a signed 32-bit integer. The operand arrives as four fields: a two-bit class, a sign, a signed unbiased exponent and a normalised mantissa whose leading one sits in its top bit. The block aligns the mantissa so that the integer part lands in the low 32 bits and folds every discarded bit into a single sticky term. It truncates toward zero, detects overflow, and returns the integer along with an inexact flag and an operand-error flag.

An exponent of 0 means a magnitude in [1,2). A magnitude that does not fit saturates asymmetrically: positive values go to 0x7FFFFFFF and negative values go to 0x80000000. Infinities and NaNs saturate in the same way. Inputs that truncate to zero only raise inexact, and the block has no underflow indication. The result and flags are registered, and `out_valid` follows `in_valid` by one clock.

Top module: `fp_to_int32`

## Requirements
- R1: A class-zero input (in_class = 0) yields out_int = 0 with out_inexact and out_operr both clear.
- R2: An infinity (in_class = 2) or NaN (in_class = 3) input sets out_operr, clears out_inexact, and yields 0x7FFFFFFF when in_sign is 0 and 0x80000000 when in_sign is 1.
- R3: A number (in_class = 1) with exponent of 32 or more saturates as in R2, with out_operr set and out_inexact clear.
- R4: For a number with exponent e in 0..31, the magnitude is floor(mant / 2^(MW-1-e)), that is, truncation toward zero.
- R5: For a non-overflowing number, out_inexact is set exactly when the truncation discarded a nonzero bit, and out_operr is clear.
- R6: A number with a negative exponent yields out_int = 0 with out_inexact set when the mantissa is nonzero, and no error is flagged.
- R7: A truncated magnitude of exactly 2^31 overflows when positive, giving 0x7FFFFFFF with out_operr set. When negative it is in range and gives 0x80000000 with out_operr clear.
- R8: A non-overflowing negative number yields the two's-complement negation of its magnitude.
- R9: out_valid is high in the cycle after in_valid is high and low otherwise. out_int and the flags keep their values while in_valid is low.
- R10: After reset, out_valid, out_int, out_inexact and out_operr are all zero.
- R11: out_operr and out_inexact are never set together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operand valid this cycle |
| in_class | input | 2 | 0 zero, 1 number, 2 infinity, 3 NaN |
| in_sign | input | 1 | 1 for negative |
| in_exp | input | EW (16) | Signed unbiased exponent |
| in_mant | input | MW (64) | Mantissa, leading one in the top bit |
| out_valid | output | 1 | Result valid |
| out_int | output | IW (32) | Signed integer result |
| out_inexact | output | 1 | Nonzero bits were discarded |
| out_operr | output | 1 | Overflow or non-number operand |

## Verification
The bench sweeps exponents from well below zero to well above 31, including the extremes of the 16-bit field. It covers several mantissa patterns with both signs across all four classes. The 2^31 boundary is the sharpest corner: a design with a symmetric overflow test would reject the exact negative minimum or accept positive 2^31. An exponent of 31 with extra fraction bits checks that sticky does not push a negative 2^31 into overflow. Negative exponents check that everything shifts out, so that a wrapped shift count does not produce a nonzero integer. Idle cycles check that the outputs hold, and overflow cases check that inexact is replaced rather than combined with operand-error.

// File: rtl/fp_to_int32.sv
module fp_to_int32 #(
  parameter int MW = 64,
  parameter int EW = 16,
  parameter int IW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [1:0]    in_class,
  input  logic          in_sign,
  input  logic [EW-1:0] in_exp,
  input  logic [MW-1:0] in_mant,
  output logic          out_valid,
  output logic [IW-1:0] out_int,
  output logic          out_inexact,
  output logic          out_operr
);
  localparam logic [IW-1:0] HALF = {1'b1, {(IW-1){1'b0}}};
  localparam logic [IW-1:0] POS_SAT = {1'b0, {(IW-1){1'b1}}};

  logic            is_num, is_zero, exp_neg, exp_big, ovf, frac_nz, operr;
  logic [EW-1:0]   sh;
  logic [2*MW-1:0] aligned;
  logic [IW-1:0]   mag, res;

  assign is_zero = in_class == 2'd0;
  assign is_num  = in_class == 2'd1;
  assign exp_neg = in_exp[EW-1];
  assign exp_big = !exp_neg && (in_exp >= EW'(IW));
  assign sh      = EW'(MW - 1) - in_exp;
  assign aligned = {in_mant, {MW{1'b0}}} >> sh;

  always_comb begin
    if (exp_neg || exp_big) begin
      mag     = '0;
      frac_nz = |in_mant;
    end else begin
      mag     = aligned[MW +: IW];
      frac_nz = |aligned[MW-1:0];
    end
  end

  assign ovf   = exp_big || (mag > HALF) || (mag == HALF && !in_sign);
  assign operr = !is_zero && (!is_num || ovf);

  always_comb begin
    if (operr)        res = in_sign ? HALF : POS_SAT;
    else if (is_zero) res = '0;
    else              res = in_sign ? (~mag + 1'b1) : mag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_int     <= '0;
      out_inexact <= 1'b0;
      out_operr   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_int     <= res;
        out_operr   <= operr;
        out_inexact <= is_num && !operr && frac_nz;
      end
    end
  end
endmodule

module fp_to_int32_chk #(
  parameter int EW = 16,
  parameter int IW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [1:0]    in_class,
  input logic          in_sign,
  input logic [EW-1:0] in_exp,
  input logic          out_valid,
  input logic [IW-1:0] out_int,
  input logic          out_inexact,
  input logic          out_operr
);
  // R9
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R9
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && $stable(out_int) && $stable(out_operr));
  // R11
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_operr && out_inexact));
  // R1
  zero_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_class == 2'd0 |=> out_int == '0 && !out_operr && !out_inexact);
  // R2
  nonnum_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_class[1] |=> out_operr && !out_inexact &&
      out_int == ($past(in_sign) ? {1'b1, {(IW-1){1'b0}}} : {1'b0, {(IW-1){1'b1}}}));
  // R3
  big_exp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_class == 2'd1 && !in_exp[EW-1] && in_exp >= EW'(IW) |=> out_operr);
  // R6
  neg_exp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_class == 2'd1 && in_exp[EW-1] |=> out_int == '0 && !out_operr);
endmodule

bind fp_to_int32 fp_to_int32_chk #(.EW(EW), .IW(IW)) chk_i (.*);

// File: tb/tb_fp_to_int32.sv
`timescale 1ns/1ps
module tb_fp_to_int32;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  in_class = 2'd0;
  logic        in_sign = 1'b0;
  logic [15:0] in_exp = '0;
  logic [63:0] in_mant = '0;
  logic        out_valid;
  logic [31:0] out_int;
  logic        out_inexact, out_operr;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  fp_to_int32 dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(input logic [1:0] cls, input logic sg, input int e, input logic [63:0] m);
    logic [31:0] x_int, hold;
    logic x_inx, x_op, ovf;
    logic [63:0] q, r, den;
    string req;
    x_inx = 1'b0; x_op = 1'b0; ovf = 1'b0; q = '0; r = '0;
    if (cls == 2'd0) begin req = "R1"; x_int = '0; end
    else if (cls != 2'd1) begin req = "R2"; ovf = 1'b1; end
    else if (e >= 32) begin req = "R3"; ovf = 1'b1; end
    else begin
      if (e < 0) begin req = "R6"; q = '0; r = m; end
      else begin
        req = sg ? "R8" : "R4";
        den = 64'd1 << (63 - e);
        q = m / den; r = m % den;
        if (q == 64'h8000_0000) req = "R7";
      end
      if (q > 64'h8000_0000 || (q == 64'h8000_0000 && !sg)) ovf = 1'b1;
      x_inx = !ovf && r != 0;
    end
    if (ovf) begin
      x_op = 1'b1;
      x_int = sg ? 32'h8000_0000 : 32'h7FFF_FFFF;
    end else if (cls == 2'd1) x_int = sg ? 32'(-q) : q[31:0];
    @(negedge clk);
    in_valid = 1'b1; in_class = cls; in_sign = sg; in_exp = 16'(e); in_mant = m;
    @(negedge clk);
    in_valid = 1'b0; in_class = ~cls; in_sign = ~sg; in_mant = ~m;
    chk({req, " int"}, out_int, x_int);
    chk({req, " operr"}, 32'(out_operr), 32'(x_op));
    chk({req, " R5 inexact"}, 32'(out_inexact), 32'(x_inx));
    chk("R9 valid", 32'(out_valid), 32'd1);
    hold = out_int;
    @(negedge clk);
    chk("R9 idle", 32'(out_valid), 32'd0);
    chk("R9 hold", out_int, hold);
  endtask

  initial begin
    logic [63:0] pats [6];
    pats[0] = 64'h8000_0000_0000_0000;
    pats[1] = 64'hFFFF_FFFF_FFFF_FFFF;
    pats[2] = 64'h8000_0000_0000_0001;
    pats[3] = 64'h8000_0000_8000_0000;
    pats[4] = 64'hA5A5_5A5A_F0F0_0F0F;
    pats[5] = 64'hC000_0001_0000_0000;
    #1;
    // R10
    chk("R10 valid", 32'(out_valid), 32'd0);
    chk("R10 int", out_int, 32'd0);
    chk("R10 flags", {30'd0, out_inexact, out_operr}, 32'd0);
    #9 rst_n = 1'b1;
    for (int c = 0; c < 4; c++)
      for (int s = 0; s < 2; s++)
        run(2'(c), s[0], 5, pats[4]);
    for (int s = 0; s < 2; s++)
      for (int p = 0; p < 6; p++) begin
        for (int e = -6; e <= 40; e++) run(2'd1, s[0], e, pats[p]);
        run(2'd1, s[0], -32768, pats[p]);
        run(2'd1, s[0], 32767, pats[p]);
        run(2'd1, s[0], 63, pats[p]);
      end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule